// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block sits inside a debug breakpoint unit and watches, one per clock, a stream of bus cycle descriptors. Each descriptor tells which bus carried the cycle (the CPU-side bus or the internal bus), who mastered an internal-bus cycle (CPU or DMA), whether it was an instruction fetch or a data access, its direction, and its address. When a valid descriptor satisfies the programmed condition, the block raises a one-clock break request on the following clock and sets a sticky match flag.

The condition is programmed through a small register write port. Four 2-bit select fields (direction, access kind, bus hierarchy, bus master) qualify the cycle, and an address with a don't-care mask qualifies the address. Every select field has its own "off" code 00. The hierarchy field also decides whether the master field is read at all. Any field at 00 switches the whole comparison off.

Top module: `brk_cond_matcher`

## Requirements
- R1: After synchronous reset the break pulse and sticky flag are 0 and all four select fields are 00, so even a descriptor that matches the address cannot raise a break.
- R2: Whenever any one of the four select fields holds 00, no break is raised, whatever the descriptor.
- R3: Hierarchy field (register 0, bits [5:4]): 01 and 11 accept only CPU-side bus cycles (cyc_ibus=0), and 10 accepts only internal-bus cycles (cyc_ibus=1).
- R4: With the hierarchy field at 10, the master field (register 0, bits [7:6]) accepts CPU-mastered cycles (cyc_dma=0) for 01 and 11, and DMA-mastered cycles (cyc_dma=1) for 10.
- R5: With the hierarchy field at 01 or 11, any nonzero master field value has no effect and cyc_dma is ignored.
- R6: Kind field (register 0, bits [3:2]): 01 accepts fetches (cyc_fetch=1), 10 accepts data accesses, and 11 accepts both. A fetch seen on the internal bus never matches.
- R7: Direction field (register 0, bits [1:0]): 01 accepts reads (cyc_write=0), 10 accepts writes, and 11 accepts both.
- R8: The address qualifies when ((cyc_addr XOR address register 1) AND NOT mask register 2) is zero, so a mask bit of 1 marks that bit as don't care.
- R9: A descriptor is considered only while cyc_valid is 1. A qualifying descriptor sampled at edge N gives brk_pulse high for exactly the clock that follows edge N.
- R10: The sticky flag is set together with every break pulse. Writing register 3 with bit 0 set clears it. When a set and a clear fall in the same cycle, the flag stays set.
- R11: A register write sampled at edge N applies to descriptors from edge N+1 onward. A descriptor sampled at edge N still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 select fields, 1 address, 2 mask, 3 control |
| cfg_wdata | input | ADDR_W | Register write data |
| cyc_valid | input | 1 | Descriptor valid strobe |
| cyc_ibus | input | 1 | 1 = internal bus cycle, 0 = CPU-side bus cycle |
| cyc_dma | input | 1 | 1 = DMA-mastered internal bus cycle |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | ADDR_W | Cycle address |
| brk_pulse | output | 1 | Registered one-clock break request |
| brk_sticky | output | 1 | Sticky match flag |

## Verification
The hardest situations to reach are the ones where two rules interact. One is a fetch on the internal bus while the kind field accepts both kinds. Another is a DMA cycle on the CPU-side bus while the master field asks for DMA. The third is a set and a clear of the sticky flag in the same clock. Directed steps build each of these on purpose. Random descriptors then draw addresses from the programmed address with flips inside and outside the mask, so address hits are frequent. Random register writes seldom leave a field at 00, which keeps the condition live most of the time.

// File: rtl/bkm_pkg.sv
package bkm_pkg;

    typedef enum logic [1:0] {
        REG_SEL  = 2'd0,
        REG_ADDR = 2'd1,
        REG_MASK = 2'd2,
        REG_CTRL = 2'd3
    } cfg_reg_e;

    localparam int CTRL_CLR_BIT = 0;

    typedef struct packed {
        logic [1:0] master;
        logic [1:0] hier;
        logic [1:0] kind;
        logic [1:0] dir;
    } sel_fields_t;

    typedef struct packed {
        logic ibus;
        logic dma;
        logic fetch;
        logic write;
    } cyc_attr_t;

    function automatic logic any_off(sel_fields_t s);
        return (s.master == 2'b00) || (s.hier == 2'b00) ||
               (s.kind == 2'b00) || (s.dir == 2'b00);
    endfunction

    function automatic logic hier_ok(logic [1:0] h, logic ibus);
        case (h)
            2'b01, 2'b11: return !ibus;
            2'b10:        return ibus;
            default:      return 1'b0;
        endcase
    endfunction

    function automatic logic master_ok(logic [1:0] m, logic [1:0] h, logic dma);
        if (m == 2'b00)
            return 1'b0;
        if (h != 2'b10)
            return 1'b1;
        case (m)
            2'b10:   return dma;
            default: return !dma;
        endcase
    endfunction

    function automatic logic kind_ok(logic [1:0] k, logic fetch, logic ibus);
        case (k)
            2'b01:   return fetch && !ibus;
            2'b10:   return !fetch;
            2'b11:   return fetch ? !ibus : 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic dir_ok(logic [1:0] d, logic write);
        case (d)
            2'b01:   return !write;
            2'b10:   return write;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bkm_cfg_regs.sv
module bkm_cfg_regs
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        waddr,
    input  logic [ADDR_W-1:0] wdata,
    output sel_fields_t       sel,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic [ADDR_W-1:0] cmp_mask,
    output logic              clr_req
);
    localparam int SEL_W = $bits(sel_fields_t);

    cfg_reg_e idx;
    assign idx = cfg_reg_e'(waddr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel      <= '0;
            cmp_addr <= '0;
            cmp_mask <= '0;
        end else if (we) begin
            case (idx)
                REG_SEL:  sel      <= sel_fields_t'(wdata[SEL_W-1:0]);
                REG_ADDR: cmp_addr <= wdata;
                REG_MASK: cmp_mask <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr_req = we && (idx == REG_CTRL) && wdata[CTRL_CLR_BIT];

endmodule

// File: rtl/bkm_cond_eval.sv
module bkm_cond_eval
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  sel_fields_t       sel,
    input  cyc_attr_t         attr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] cmp_mask,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
        assign bit_ok[i] = cmp_mask[i] || (addr[i] == cmp_addr[i]);
    end

    logic attr_ok;
    always_comb begin
        attr_ok = !any_off(sel) &&
                  hier_ok(sel.hier, attr.ibus) &&
                  master_ok(sel.master, sel.hier, attr.dma) &&
                  kind_ok(sel.kind, attr.fetch, attr.ibus) &&
                  dir_ok(sel.dir, attr.write);
    end

    assign hit = attr_ok && (&bit_ok);

endmodule

// File: rtl/bkm_break_out.sv
module bkm_break_out (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic hit,
    input  logic clr_req,
    output logic pulse,
    output logic sticky
);
    logic set_now;
    assign set_now = valid && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            sticky <= 1'b0;
        end else begin
            pulse  <= set_now;
            sticky <= set_now || (sticky && !clr_req);
        end
    end

endmodule

// File: rtl/brk_cond_matcher.sv
module brk_cond_matcher
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cyc_valid,
    input  logic              cyc_ibus,
    input  logic              cyc_dma,
    input  logic              cyc_fetch,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              brk_pulse,
    output logic              brk_sticky
);
    sel_fields_t       sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    logic              clr_req;
    logic              hit;
    cyc_attr_t         attr;

    assign attr = '{ibus: cyc_ibus, dma: cyc_dma, fetch: cyc_fetch, write: cyc_write};

    bkm_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .sel      (sel_q),
        .cmp_addr (addr_q),
        .cmp_mask (mask_q),
        .clr_req  (clr_req)
    );

    bkm_cond_eval #(.ADDR_W(ADDR_W)) u_eval (
        .sel      (sel_q),
        .attr     (attr),
        .addr     (cyc_addr),
        .cmp_addr (addr_q),
        .cmp_mask (mask_q),
        .hit      (hit)
    );

    bkm_break_out u_out (
        .clk     (clk),
        .rst     (rst),
        .valid   (cyc_valid),
        .hit     (hit),
        .clr_req (clr_req),
        .pulse   (brk_pulse),
        .sticky  (brk_sticky)
    );

endmodule

// File: rtl/bkm_checker.sv
module bkm_checker
    import bkm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cyc_valid,
    input logic        cyc_ibus,
    input logic        cyc_dma,
    input logic        cyc_fetch,
    input sel_fields_t sel,
    input logic        clr_req,
    input logic        brk_pulse,
    input logic        brk_sticky
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!brk_pulse && !brk_sticky));

    // R2
    disabled_field_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel.master == 2'b00) || (sel.hier == 2'b00) ||
         (sel.kind == 2'b00) || (sel.dir == 2'b00)) |=> !brk_pulse);

    // R4
    dma_select_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && sel.hier == 2'b10 && sel.master == 2'b10 && !cyc_dma) |=> !brk_pulse);

    // R6
    ibus_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_ibus && cyc_fetch) |=> !brk_pulse);

    // R9
    valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> !brk_pulse);

    // R10
    sticky_follows_chk: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |-> brk_sticky);

    // R10
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_sticky) |-> $past(clr_req));

endmodule

bind brk_cond_matcher bkm_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .cyc_valid  (cyc_valid),
    .cyc_ibus   (cyc_ibus),
    .cyc_dma    (cyc_dma),
    .cyc_fetch  (cyc_fetch),
    .sel        (sel_q),
    .clr_req    (clr_req),
    .brk_pulse  (brk_pulse),
    .brk_sticky (brk_sticky)
);

// File: tb/brk_cond_matcher_tb_top.sv
`timescale 1ns/1ps
module brk_cond_matcher_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          cyc_valid = 1'b0;
    logic          cyc_ibus = 1'b0;
    logic          cyc_dma = 1'b0;
    logic          cyc_fetch = 1'b0;
    logic          cyc_write = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic          brk_pulse;
    logic          brk_sticky;

    always #5 clk = ~clk;

    brk_cond_matcher #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cyc_valid(cyc_valid), .cyc_ibus(cyc_ibus),
        .cyc_dma(cyc_dma), .cyc_fetch(cyc_fetch), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .brk_pulse(brk_pulse), .brk_sticky(brk_sticky)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]    m_sel = '0;
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_mask = '0;
    bit            m_sticky = 0;

    function automatic bit ref_hit(logic [7:0] s, bit ib, bit dm, bit fe, bit wr,
                                   logic [AW-1:0] a, logic [AW-1:0] ca, logic [AW-1:0] cm);
        logic [1:0] fm, fh, fk, fd;
        fm = s[7:6]; fh = s[5:4]; fk = s[3:2]; fd = s[1:0];
        if (fm == 0 || fh == 0 || fk == 0 || fd == 0) return 0;
        if (fh == 2'b10) begin
            if (!ib) return 0;
            if ((fm == 2'b10) ? !dm : dm) return 0;
        end else if (ib) return 0;
        if (fe) begin
            if (fk == 2'b10 || ib) return 0;
        end else if (fk == 2'b01) return 0;
        if (wr ? (fd == 2'b01) : (fd == 2'b10)) return 0;
        return ((a ^ ca) & ~cm) == '0;
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit v, bit ib, bit dm, bit fe, bit wr, logic [AW-1:0] a,
                        bit we, logic [1:0] wa, logic [AW-1:0] wd, string tag);
        bit exp_p, exp_s, clr;
        cyc_valid = v; cyc_ibus = ib; cyc_dma = dm; cyc_fetch = fe; cyc_write = wr;
        cyc_addr = a; cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        exp_p = v && ref_hit(m_sel, ib, dm, fe, wr, a, m_addr, m_mask);
        clr   = we && (wa == 2'd3) && wd[0];
        exp_s = exp_p || (m_sticky && !clr);
        check(tag, "pulse", brk_pulse, exp_p);
        check(tag, "sticky", brk_sticky, exp_s);
        if (we) begin
            case (wa)
                2'd0: m_sel  = wd[7:0];
                2'd1: m_addr = wd;
                2'd2: m_mask = wd;
                default: ;
            endcase
        end
        m_sticky = exp_s;
        cfg_we = 0;
        cyc_valid = 0;
    endtask

    task automatic wr_reg(logic [1:0] wa, logic [AW-1:0] wd, string tag);
        step(0, 0, 0, 0, 0, '0, 1, wa, wd, tag);
    endtask

    localparam logic [AW-1:0] BASE = 32'h1000_0040;

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "pulse", brk_pulse, 1'b0);
        check("R1", "sticky", brk_sticky, 1'b0);
        rst = 0;
        // R1: fields at 00 after reset, address 0 matches address register 0
        step(1, 0, 0, 1, 0, '0, 0, 0, '0, "R1");

        wr_reg(1, BASE, "R8");
        wr_reg(2, 32'h0000_000F, "R8");
        wr_reg(0, 32'h5F, "R9");
        // R9
        step(1, 0, 0, 1, 0, BASE | 32'h3, 0, 0, '0, "R9");
        step(0, 0, 0, 1, 0, BASE | 32'h3, 0, 0, '0, "R9");
        // R8
        step(1, 0, 0, 1, 0, BASE ^ 32'h10, 0, 0, '0, "R8");
        step(1, 0, 0, 1, 0, BASE | 32'hF, 0, 0, '0, "R8");
        // R7
        wr_reg(0, 32'h5D, "R7");
        step(1, 0, 0, 0, 1, BASE, 0, 0, '0, "R7");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R7");
        wr_reg(0, 32'h5E, "R7");
        step(1, 0, 0, 0, 1, BASE, 0, 0, '0, "R7");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R7");
        // R3
        wr_reg(0, 32'h7F, "R3");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R3");
        step(1, 1, 0, 0, 0, BASE, 0, 0, '0, "R3");
        wr_reg(0, 32'h6F, "R3");
        step(1, 1, 0, 0, 0, BASE, 0, 0, '0, "R3");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R3");
        // R4
        wr_reg(0, 32'hAF, "R4");
        step(1, 1, 1, 0, 1, BASE, 0, 0, '0, "R4");
        step(1, 1, 0, 0, 1, BASE, 0, 0, '0, "R4");
        wr_reg(0, 32'hEF, "R4");
        step(1, 1, 0, 0, 0, BASE, 0, 0, '0, "R4");
        step(1, 1, 1, 0, 0, BASE, 0, 0, '0, "R4");
        // R5
        wr_reg(0, 32'h9F, "R5");
        step(1, 0, 1, 0, 0, BASE, 0, 0, '0, "R5");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R5");
        // R6
        wr_reg(0, 32'h57, "R6");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R6");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R6");
        wr_reg(0, 32'h5B, "R6");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R6");
        step(1, 0, 0, 0, 0, BASE, 0, 0, '0, "R6");
        wr_reg(0, 32'h6F, "R6");
        step(1, 1, 0, 1, 0, BASE, 0, 0, '0, "R6");
        // R2: each field off in turn
        wr_reg(0, 32'h1F, "R2");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R2");
        wr_reg(0, 32'h4F, "R2");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R2");
        wr_reg(0, 32'h53, "R2");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R2");
        wr_reg(0, 32'h5C, "R2");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R2");
        // R10: clear, then set and clear together
        wr_reg(3, 32'h1, "R10");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R10");
        wr_reg(0, 32'h5F, "R10");
        step(1, 0, 0, 1, 0, BASE, 1, 3, 32'h1, "R10");
        wr_reg(3, 32'h1, "R10");
        // R11: descriptor in the write cycle uses the old fields
        step(1, 0, 0, 1, 0, BASE, 1, 0, 32'h5C, "R11");
        step(1, 0, 0, 1, 0, BASE, 0, 0, '0, "R11");

        // random phase covering R3, R4, R5, R6, R7, R8 together
        for (int n = 0; n < 4000; n++) begin
            bit we;
            logic [1:0] wa;
            logic [AW-1:0] wd, a, flip;
            we = ($urandom_range(0, 9) == 0);
            wa = 2'($urandom_range(0, 3));
            if (wa == 0) begin
                wd = '0;
                for (int f = 0; f < 4; f++)
                    wd[2*f +: 2] = ($urandom_range(0, 7) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
            end else if (wa == 2) begin
                wd = $urandom() & $urandom() & $urandom();
            end else if (wa == 3) begin
                wd = ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h0;
            end else begin
                wd = $urandom();
            end
            flip = ($urandom_range(0, 1) == 1) ? ($urandom() & m_mask)
                                               : ($urandom() & $urandom() & $urandom() & $urandom());
            a = m_addr ^ flip;
            step($urandom_range(0, 3) != 0, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                 1'($urandom()), a, we, wa, wd, "R3_R8_rand");
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule